// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read a serial NOR flash as if it were plain memory. A single mode bit, driven from outside the block, chooses between command mode and mapped mode. In command mode the mapped port accepts nothing. In mapped mode, a one-word bus read at an address in the mapped window is turned into a full flash read. The engine selects the chip, shifts out a read opcode and a chosen number of address bytes, waits a chosen number of dummy clocks, and then gathers four data bytes on one, two or four data lines. It then releases the chip and hands the 32-bit word back to the bus.

Each chip select has its own 32-bit setup word. The engine picks the setup word from the address bits above the 24-bit flash address. From that word it takes the opcode, the address length, the dummy length and the data lane count. The serial clock runs at half the system clock and idles low. The flash samples on the rising serial-clock edge, and the engine samples flash data at that same point.

Top module: `mmap_flash_reader`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, no line is driven (`flash_io_oe` = 0), `rd_valid` is low and no request is accepted without `rd_req`.
- R2: While `map_en` is 0, a held `rd_req` is never acknowledged and no chip select goes low. Once `map_en` is 1, the held request is accepted.
- R3: After the chip select falls, the opcode from setup bits 7:0 goes out MSB first on `flash_io_out[0]`. Each bit is stable at the rising serial-clock edge, and only line 0 is driven.
- R4: Setup bits 9:8 give N address bytes (0 to 3). The low N bytes of the 24-bit flash address follow the opcode, MSB first, on line 0. With N = 0 the address phase is skipped.
- R5: After the address come 8 × (setup bits 11:10) plus (setup bits 28:24) dummy clocks. During these no line is driven, and the total count of serial clocks equals the opcode, address, dummy and data phases added together.
- R6: Setup bits 13:12 select the data lanes. 0 means one lane, read from line 1. 1 means two lanes, line 1 holding the more significant bit. 3 means four lanes, line 3 the most significant. The value 2 behaves as one lane.
- R7: Four bytes are received, each MSB first, and the first byte received lands in `rd_data[7:0]`, the last in `rd_data[31:24]`.
- R8: The chip select rises before `rd_valid`. `rd_valid` is a single-cycle pulse carrying the word.
- R9: Address bits above the 24-bit flash address choose the chip select and its setup word. At most one chip select is low at a time.
- R10: A request made while a read is in progress is not acknowledged until that read has delivered its word. It is served afterwards.
- R11: Setup bits 15:14, 23:16 and 31:29 have no effect on the read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_en | input | 1 | 1 = mapped mode, 0 = command mode |
| setup_words | input | 32*NUM_CS | One packed setup word per chip select, slot 0 in the low bits |
| rd_req | input | 1 | Bus read request, held until acknowledged |
| rd_addr | input | CS_W+24 | Chip select index in the top bits, flash byte address below |
| rd_ack | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | One-cycle pulse with the read word |
| rd_data | output | 32 | Read word, little-endian |
| flash_sclk | output | 1 | Serial clock, idle low |
| flash_cs_n | output | NUM_CS | Active-low chip selects |
| flash_io_out | output | 4 | Values driven to the flash data lines |
| flash_io_oe | output | 4 | Output enables for the data lines |
| flash_io_in | input | 4 | Values read from the flash data lines |

## Verification
The assertions check on every cycle that at most one chip select is low, that line 0 never changes on a rising serial-clock edge, that a chip select is low right after an accepted start, that an acknowledge always puts the engine in a busy state, and that the read-valid pulse is one cycle long and comes with every chip select high. Only the bench scenarios can show the content of a read. A flash model on the bench records the opcode and address bits, counts the dummy clocks and the line enables, and serves data on the selected lanes. From these it shows the lane ordering, the byte order of the word, the effect of the setup fields and the ignored bits, and the holding off of requests during command mode and during a busy read.

// File: rtl/mfr_pkg.sv
// Shared types and helpers for the mapped flash read engine.
// Assumes 24-bit flash byte addresses and 32-bit setup words.
package mfr_pkg;

    localparam int FLASH_AW = 24;

    // Internal lane-count encoding, decoupled from the setup field code.
    typedef enum logic [1:0] {
        LN_X1 = 2'd0,
        LN_X2 = 2'd1,
        LN_X4 = 2'd2
    } lane_e;

    // Read sequence configuration decoded from one setup word.
    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] addr_bytes;
        logic [6:0] wait_cycles;
        lane_e      lanes;
    } rd_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_DATA,
        ST_END
    } seq_st_e;

    // Map the two-bit lane field; the unassigned code falls back to one lane.
    function automatic lane_e lane_of(input logic [1:0] code);
        case (code)
            2'b01:   return LN_X2;
            2'b11:   return LN_X4;
            default: return LN_X1;
        endcase
    endfunction

    // Number of data slots minus one for 32 data bits.
    function automatic logic [6:0] data_slots_m1(input lane_e l);
        case (l)
            LN_X2:   return 7'd15;
            LN_X4:   return 7'd7;
            default: return 7'd31;
        endcase
    endfunction

    // Reorder a receive stream (first byte in the top) into a little-endian word.
    function automatic logic [31:0] le_word(input logic [31:0] s);
        return {s[7:0], s[15:8], s[23:16], s[31:24]};
    endfunction

endpackage

// File: rtl/mfr_setup_decode.sv
// Decodes one packed setup word per chip select and selects the one
// addressed by the request. Purely combinational.
// Assumes sel is below NUM_CS.
module mfr_setup_decode
    import mfr_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1
) (
    input  logic [NUM_CS*32-1:0] setup_words,
    input  logic [CS_W-1:0]      sel,
    output rd_cfg_t              cfg
);

    rd_cfg_t slot_cfg [NUM_CS];

    // One decoder per chip-select slot.
    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
            logic [31:0] w;
            logic        unused_fields;
            assign w = setup_words[g*32 +: 32];
            // Write opcode and reserved bits take no part in reads (R11).
            assign unused_fields = ^{w[31:29], w[23:14]};
            assign slot_cfg[g] = '{
                opcode:      w[7:0],
                addr_bytes:  w[9:8],
                wait_cycles: 7'({w[11:10], 3'b000}) + 7'(w[28:24]),
                lanes:       lane_of(w[13:12])
            };
        end
    endgenerate

    // Pick the addressed slot.
    assign cfg = slot_cfg[sel];

endmodule

// File: rtl/mfr_seq.sv
// Serial flash read sequencer: opcode, address, dummy and data phases.
// The serial clock is clk/2 and idles low. Each serial bit spans two
// clk cycles: a low half, where outputs change, and a high half.
// Input data is captured as the serial clock rises.
// Assumes start is raised only while busy is low.
module mfr_seq
    import mfr_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  rd_cfg_t             cfg,
    input  logic [FLASH_AW-1:0] flash_addr,
    input  logic [CS_W-1:0]     cs_sel,
    output logic                busy,
    output logic                sclk,
    output logic [NUM_CS-1:0]   cs_n,
    output logic [3:0]          io_out,
    output logic [3:0]          io_oe,
    input  logic [3:0]          io_in,
    output logic                word_valid,
    output logic [31:0]         word_data
);

    seq_st_e         state;
    logic            half;
    logic [6:0]      cnt;
    logic [31:0]     tx_sr;
    logic [31:0]     rx_sr;
    rd_cfg_t         cfg_q;
    logic [CS_W-1:0] cs_q;
    logic [4:0]      addr_shift;
    logic            active;

    // Left-justify the low address bytes under the opcode.
    assign addr_shift = {2'd3 - cfg.addr_bytes, 3'b000};
    assign active     = (state == ST_CMD) || (state == ST_WAIT) || (state == ST_DATA);
    assign busy       = (state != ST_IDLE);
    assign sclk       = half;
    assign io_out     = {3'b000, tx_sr[31]};
    assign io_oe      = {3'b000, state == ST_CMD};

    // Drive the addressed chip select low during the active phases.
    always_comb begin
        cs_n = '1;
        if (active) cs_n[cs_q] = 1'b0;
    end

    // Phase sequencing, serial clock halves, shifting and word delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            half       <= 1'b0;
            cnt        <= '0;
            tx_sr      <= '0;
            rx_sr      <= '0;
            cfg_q      <= '0;
            cs_q       <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q <= cfg;
                        cs_q  <= cs_sel;
                        tx_sr <= {cfg.opcode, flash_addr << addr_shift};
                        cnt   <= {2'b00, cfg.addr_bytes, 3'b111};
                        half  <= 1'b0;
                        state <= ST_CMD;
                    end
                end
                ST_CMD, ST_WAIT, ST_DATA: begin
                    if (!half) begin
                        half <= 1'b1;
                        if (state == ST_DATA) begin
                            case (cfg_q.lanes)
                                LN_X2:   rx_sr <= {rx_sr[29:0], io_in[1:0]};
                                LN_X4:   rx_sr <= {rx_sr[27:0], io_in};
                                default: rx_sr <= {rx_sr[30:0], io_in[1]};
                            endcase
                        end
                    end else begin
                        half <= 1'b0;
                        if (state == ST_CMD) tx_sr <= tx_sr << 1;
                        if (cnt != 7'd0) begin
                            cnt <= cnt - 7'd1;
                        end else if (state == ST_CMD) begin
                            if (cfg_q.wait_cycles != 7'd0) begin
                                state <= ST_WAIT;
                                cnt   <= cfg_q.wait_cycles - 7'd1;
                            end else begin
                                state <= ST_DATA;
                                cnt   <= data_slots_m1(cfg_q.lanes);
                            end
                        end else if (state == ST_WAIT) begin
                            state <= ST_DATA;
                            cnt   <= data_slots_m1(cfg_q.lanes);
                        end else begin
                            state <= ST_END;
                        end
                    end
                end
                ST_END: begin
                    word_valid <= 1'b1;
                    word_data  <= le_word(rx_sr);
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: never more than one chip selected.
    assert_single_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R3: line 0 holds steady across every rising serial-clock edge.
    assert_io_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(io_out));

    // R3: an accepted start selects a chip on the next cycle.
    assert_start_selects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !(&cs_n));

    // R8: the word is delivered with the chip released.
    assert_valid_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (&cs_n));

    // R8: the valid strobe lasts one cycle.
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

endmodule

// File: rtl/mmap_flash_reader.sv
// Top of the mapped flash read engine. Gates bus requests on the mode
// bit and the engine being idle, decodes the addressed setup word and
// runs the sequencer. Assumes rd_req is held until rd_ack.
module mmap_flash_reader
    import mfr_pkg::*;
#(
    parameter  int NUM_CS = 2,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W = CS_W + FLASH_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_en,
    input  logic [NUM_CS*32-1:0] setup_words,
    input  logic                 rd_req,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_ack,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic                 flash_sclk,
    output logic [NUM_CS-1:0]    flash_cs_n,
    output logic [3:0]           flash_io_out,
    output logic [3:0]           flash_io_oe,
    input  logic [3:0]           flash_io_in
);

    rd_cfg_t         cfg;
    logic            busy;
    logic [CS_W-1:0] sel;

    assign sel = rd_addr[ADDR_W-1 -: CS_W];

    // Accept only in mapped mode with the sequencer idle (R2, R10).
    assign rd_ack = rd_req & map_en & ~busy;

    mfr_setup_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_decode (
        .setup_words (setup_words),
        .sel         (sel),
        .cfg         (cfg)
    );

    mfr_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_ack),
        .cfg        (cfg),
        .flash_addr (rd_addr[FLASH_AW-1:0]),
        .cs_sel     (sel),
        .busy       (busy),
        .sclk       (flash_sclk),
        .cs_n       (flash_cs_n),
        .io_out     (flash_io_out),
        .io_oe      (flash_io_oe),
        .io_in      (flash_io_in),
        .word_valid (rd_valid),
        .word_data  (rd_data)
    );

    // R10: every acknowledge puts the sequencer into a busy state.
    assert_ack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> busy);

endmodule

// File: tb/tb_mmap_flash_reader.sv
// Directed bench with a behavioural flash model on the serial lines.
module tb_mmap_flash_reader;

    localparam int NUM_CS = 2;
    localparam int ADDR_W = 25;

    logic                 clk;
    logic                 rst_n;
    logic                 map_en;
    logic [NUM_CS*32-1:0] setup_words;
    logic                 rd_req;
    logic [ADDR_W-1:0]    rd_addr;
    logic                 rd_ack;
    logic                 rd_valid;
    logic [31:0]          rd_data;
    logic                 flash_sclk;
    logic [NUM_CS-1:0]    flash_cs_n;
    logic [3:0]           flash_io_out;
    logic [3:0]           flash_io_oe;
    logic [3:0]           flash_io_in;

    int checks   = 0;
    int failures = 0;

    mmap_flash_reader #(.NUM_CS(NUM_CS)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .map_en       (map_en),
        .setup_words  (setup_words),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_ack       (rd_ack),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .flash_sclk   (flash_sclk),
        .flash_cs_n   (flash_cs_n),
        .flash_io_out (flash_io_out),
        .flash_io_oe  (flash_io_oe),
        .flash_io_in  (flash_io_in)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    // ---------------- flash model ----------------
    int          m_edges;
    int          m_txbits;
    int          m_pre;
    int          m_lanes;
    int          m_oe_err;
    logic [31:0] m_mosi;
    logic [31:0] m_stream;
    logic [1:0]  m_cs_seen;
    wire         cs_idle = &flash_cs_n;

    always @(negedge cs_idle) begin
        m_edges   = 0;
        m_mosi    = '0;
        m_oe_err  = 0;
        m_cs_seen = ~flash_cs_n;
    end

    always @(posedge flash_sclk) begin
        if (!cs_idle) begin
            if (m_edges < m_txbits) begin
                m_mosi = {m_mosi[30:0], flash_io_out[0]};
                if (flash_io_oe != 4'b0001) m_oe_err++;
            end else if (flash_io_oe != 4'b0000) begin
                m_oe_err++;
            end
            m_edges++;
        end
    end

    always @(negedge flash_sclk) begin
        int          k;
        logic [31:0] sh;
        if (!cs_idle && m_edges >= m_pre) begin
            k = m_edges - m_pre;
            if ((k + 1) * m_lanes <= 32) begin
                sh = m_stream >> (32 - (k + 1) * m_lanes);
                case (m_lanes)
                    1:       flash_io_in = {2'b10, sh[0], ~sh[0]};
                    2:       flash_io_in = {2'b01, sh[1:0]};
                    default: flash_io_in = sh[3:0];
                endcase
            end else begin
                flash_io_in = 4'b0000;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int cs, input logic [7:0] op, input int nab,
                           input int db, input int dbits, input logic [1:0] lanef,
                           input bit junk, input logic [31:0] stream);
        logic [31:0] w;
        w = {junk ? 3'b111 : 3'b000, 5'(dbits), junk ? 8'h12 : 8'h00,
             junk ? 2'b11 : 2'b00, lanef, 2'(db), 2'(nab), op};
        setup_words[cs*32 +: 32] = w;
        m_txbits = 8 + 8 * nab;
        m_pre    = m_txbits + 8 * db + dbits;
        m_lanes  = (lanef == 2'b01) ? 2 : (lanef == 2'b11) ? 4 : 1;
        m_stream = stream;
    endtask

    task automatic start_read(input int cs, input logic [23:0] addr);
        @(negedge clk);
        rd_addr = {cs[0], addr};
        rd_req  = 1'b1;
        #1;
        while (!rd_ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic finish_read(input string lane_req, input logic [7:0] op,
                               input int nab, input logic [23:0] addr,
                               input int cs, input logic [31:0] stream);
        bit          prev_idle;
        logic [31:0] exp_mosi;
        logic [31:0] exp_word;
        prev_idle = 1'b1;
        while (!rd_valid) begin
            prev_idle = cs_idle;
            @(negedge clk);
        end
        exp_mosi = (32'(op) << (8 * nab)) | (32'(addr) & ((32'd1 << (8 * nab)) - 32'd1));
        exp_word = {stream[7:0], stream[15:8], stream[23:16], stream[31:24]};
        chk("R7", {lane_req, " word"}, rd_data, exp_word);
        chk("R8", "cs high before valid", 32'(prev_idle), 32'd1);
        chk("R8", "cs high at valid", 32'(cs_idle), 32'd1);
        chk("R3", "opcode and address bits (R4)", m_mosi, exp_mosi);
        chk("R5", "serial clock count", 32'(m_edges), 32'(m_pre + 32 / m_lanes));
        chk("R5", "line enable errors", 32'(m_oe_err), 32'd0);
        chk("R9", "selected chip", 32'(m_cs_seen), 32'(2'b01 << cs));
        @(negedge clk);
        chk("R8", "valid single pulse", 32'(rd_valid), 32'd0);
    endtask

    task automatic run_read(input string tag, input int cs, input logic [7:0] op,
                            input int nab, input int db, input int dbits,
                            input logic [1:0] lanef, input bit junk,
                            input logic [23:0] addr, input logic [31:0] stream);
        set_cfg(cs, op, nab, db, dbits, lanef, junk, stream);
        start_read(cs, addr);
        finish_read(tag, op, nab, addr, cs, stream);
    endtask

    // ---------------- scenarios ----------------
    task automatic test_reset_r1;
        @(negedge clk);
        chk("R1", "cs_n", 32'(flash_cs_n), 32'h3);
        chk("R1", "sclk", 32'(flash_sclk), 32'd0);
        chk("R1", "io_oe", 32'(flash_io_oe), 32'd0);
        chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
        chk("R1", "rd_ack", 32'(rd_ack), 32'd0);
    endtask

    // R2: held request blocked in command mode, then served as a normal read.
    task automatic test_mode_gate_r2;
        int acks;
        int sel_seen;
        acks = 0;
        sel_seen = 0;
        set_cfg(0, 8'h03, 3, 0, 0, 2'b00, 1'b0, 32'hA1B2C3D4);
        @(negedge clk);
        map_en  = 1'b0;
        rd_addr = {1'b0, 24'h123456};
        rd_req  = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_ack) acks++;
            if (!cs_idle) sel_seen++;
        end
        chk("R2", "acks in command mode", 32'(acks), 32'd0);
        chk("R2", "selects in command mode", 32'(sel_seen), 32'd0);
        map_en = 1'b1;
        #1;
        chk("R2", "ack after mode set", 32'(rd_ack), 32'd1);
        @(negedge clk);
        rd_req = 1'b0;
        finish_read("R6 single", 8'h03, 3, 24'h123456, 0, 32'hA1B2C3D4);
    endtask

    // R10: second request held off until the first read delivers.
    task automatic test_busy_r10;
        int early;
        early = 0;
        set_cfg(1, 8'h6B, 3, 1, 0, 2'b01, 1'b0, 32'h2468ACE1);
        start_read(1, 24'h000FF0);
        rd_req = 1'b1;
        while (!rd_valid) begin
            if (rd_ack) early++;
            @(negedge clk);
        end
        chk("R10", "acks while busy", 32'(early), 32'd0);
        chk("R10", "first word", rd_data, 32'hE1AC6824);
        #1;
        while (!rd_ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        rd_req = 1'b0;
        finish_read("R10 queued", 8'h6B, 3, 24'h000FF0, 1, 32'h2468ACE1);
    endtask

    // Watchdog.
    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        map_en      = 1'b1;
        setup_words = '0;
        rd_req      = 1'b0;
        rd_addr     = '0;
        flash_io_in = 4'b0000;
        m_edges = 0; m_txbits = 8; m_pre = 8; m_lanes = 1; m_oe_err = 0;
        m_mosi = '0; m_stream = '0; m_cs_seen = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset_r1();
        test_mode_gate_r2();
        // R5: one dummy byte, single lane.
        run_read("R5 fast", 0, 8'h0B, 3, 1, 0, 2'b00, 1'b0, 24'hABCDEF, 32'h0F1E2D3C);
        // R6: two lanes.
        run_read("R6 dual", 0, 8'h6B, 3, 1, 0, 2'b01, 1'b0, 24'h000100, 32'h8899AABB);
        // R6, R9, R5: four lanes on chip 1 with extra dummy bits.
        run_read("R6 quad", 1, 8'h6C, 3, 1, 4, 2'b11, 1'b0, 24'hFEDCBA, 32'h13579BDF);
        // R11, R4, R6: two address bytes, code 2 lanes, junk in ignored fields.
        run_read("R11 ignored bits", 0, 8'h03, 2, 0, 3, 2'b10, 1'b1, 24'h77AA55, 32'h5A5AC33C);
        // R4: no address bytes, four lanes.
        run_read("R4 no address", 0, 8'h0B, 0, 0, 0, 2'b11, 1'b0, 24'h000000, 32'hC0FFEE11);
        test_busy_r10();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule